// File: doc/BRIEF.md
# Post-Increment Store Address Unit

This unit executes fixed-point stores that update their base register after the access. Each operation carries five things: an access size, an addressing form (immediate displacement or index register), a base register number with its value, an index value or immediate field, and the data to store. The memory write goes out at the base value as it stood before the operation. The sum of base and offset goes back to the base register as a writeback. The access and the writeback complete in the same cycle.

Requests are taken on a valid/ready handshake, one at a time. The memory write is held on a 64-bit bus with byte strobes until the memory acknowledges it. A misaligned address, or a base register number of zero, cancels the operation. In that case a one-cycle fault pulse goes out and neither the memory nor the register file sees a write. No condition or status state exists or is changed.

Top module: `postinc_store_unit`

## Requirements
- R1: The memory write address `memAddr` equals the base value `reqBase` of the accepted request, never the base plus the offset.
- R2: When the store is accepted, `wbRegNum` equals `reqBaseNum` and `wbData` equals `reqBase` plus the offset, modulo 2^64.
- R3: In displacement form (`reqIndexed`=0) with `reqSize` 0, 1 or 2, the offset is the 16-bit `reqImm` sign-extended to 64 bits.
- R4: In displacement form with `reqSize`=3, the offset is `{reqImm[13:0],2'b00}` sign-extended from its bit 15 to 64 bits; `reqImm[15:14]` have no effect.
- R5: In indexed form (`reqIndexed`=1), the offset is the full 64-bit `reqIndex`.
- R6: `reqSize` 0/1/2/3 selects 1/2/4/8 bytes taken from the low end of `reqData`. With o = `memAddr[2:0]` and n bytes, strobe bit j (enabling `memData[8j+7:8j]`) is set for j from 8-o-n to 7-o. The lowest address holds the most significant byte, so `memData` = (low n bytes of `reqData`) << 8*(8-o-n).
- R7: If `reqBase` is not a multiple of the access size, `alignFault` is high for exactly the one cycle after acceptance, with `memValid` and `wbValid` low; the unit then returns to ready.
- R8: If `reqBaseNum` is 0, `formFault` is high for exactly the one cycle after acceptance, with no memory write and no writeback; the unit then returns to ready.
- R9: A request is accepted when `reqValid` and `reqReady` are high at a clock edge. `memValid` rises in the next cycle and holds the address, strobes, data and writeback value stable until `memReady`. `wbValid` is high exactly in the cycle `memValid` and `memReady` are both high. `reqReady` is low while an operation is pending, and requests offered then are not taken.
- R10: After reset `reqReady` is 1 and `memValid`, `wbValid`, `alignFault` and `formFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation offered |
| reqReady | output | 1 | Unit idle, can take an operation |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| reqIndexed | input | 1 | 1: offset from index register, 0: from immediate |
| reqBaseNum | input | 5 | Base register number |
| reqBase | input | 64 | Base register value |
| reqIndex | input | 64 | Index register value |
| reqImm | input | 16 | Immediate displacement field |
| reqData | input | 64 | Source register value |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | 64 | Write address (old base) |
| memStrb | output | 8 | Byte-lane enables |
| memData | output | 64 | Lane-placed write data |
| wbValid | output | 1 | Base register writeback strobe |
| wbRegNum | output | 5 | Writeback register number |
| wbData | output | 64 | Updated base value |
| alignFault | output | 1 | Misaligned access, operation dropped |
| formFault | output | 1 | Base register 0, operation dropped |

## Verification
On every cycle, the assertions check the handshake rules. A pending write must hold stable, and a writeback may appear only alongside an accepted write. They also check that a fault pulse never coincides with a write, and that each active strobe pattern has a legal size and sits at an aligned address. Only the bench scenarios can show the arithmetic. That covers the old-base address, the three offset forms including the shifted doubleword immediate and its ignored top bits, and the big-endian lane placement for every size and offset. It also covers which of the two faults a bad request raises.

// File: rtl/pisu_pkg.sv
package pisu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSizeE;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } ctrlStateE;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // latch the offered operation
    logic issue;    // an operation is being presented
  } ctrlStrobesT;
endpackage

// File: rtl/pisu_lane_place.sv
module pisu_lane_place
  import pisu_pkg::*;
#(
  parameter int LANES = 8
) (
  input  accSizeE                    sizeSel,
  input  logic [$clog2(LANES)-1:0]   laneOff,
  input  logic [8*LANES-1:0]         value,
  output logic [LANES-1:0]           strb,
  output logic [8*LANES-1:0]         data
);
  localparam int OFFW = $clog2(LANES);

  logic [OFFW:0] nBytes;
  logic [OFFW:0] lo;
  logic [OFFW:0] hi;

  always_comb begin
    nBytes = (OFFW+1)'(1) << sizeSel;
    lo     = {1'b0, laneOff};
    hi     = lo + nBytes;
  end

  // lane j carries the byte at address offset LANES-1-j (big-endian)
  for (genvar j = 0; j < LANES; j++) begin : gLane
    localparam logic [OFFW:0] KPOS = (OFFW+1)'(LANES - 1 - j);
    logic            hit;
    logic [OFFW-1:0] pick;
    assign hit  = (KPOS >= lo) && (KPOS < hi);
    assign pick = OFFW'(hi - KPOS - (OFFW+1)'(1));
    assign strb[j]        = hit;
    assign data[8*j +: 8] = hit ? value[8*pick +: 8] : 8'h00;
  end
endmodule

// File: rtl/pisu_datapath.sv
module pisu_datapath
  import pisu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int IMMW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  accSizeE           reqSize,
  input  logic              reqIndexed,
  input  logic [REGW-1:0]   reqBaseNum,
  input  logic [XLEN-1:0]   reqBase,
  input  logic [XLEN-1:0]   reqIndex,
  input  logic [IMMW-1:0]   reqImm,
  input  logic [XLEN-1:0]   reqData,
  output logic              opMisaligned,
  output logic              opBaseZero,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN/8-1:0] memStrb,
  output logic [XLEN-1:0]   memData,
  output logic [REGW-1:0]   wbRegNum,
  output logic [XLEN-1:0]   wbData
);
  localparam int LANES = XLEN / 8;
  localparam int OFFW  = $clog2(LANES);

  logic [IMMW-1:0]  dsField;
  logic [XLEN-1:0]  dispOff;
  logic [XLEN-1:0]  dsOff;
  logic [XLEN-1:0]  offsetNext;

  always_comb begin
    dsField    = {reqImm[IMMW-3:0], 2'b00};
    dispOff    = {{(XLEN-IMMW){reqImm[IMMW-1]}}, reqImm};
    dsOff      = {{(XLEN-IMMW){dsField[IMMW-1]}}, dsField};
    if (reqIndexed)                offsetNext = reqIndex;
    else if (reqSize == SZ_DWORD)  offsetNext = dsOff;
    else                           offsetNext = dispOff;
  end

  logic [XLEN-1:0] baseQ;
  logic [XLEN-1:0] offsetQ;
  logic [XLEN-1:0] dataQ;
  logic [REGW-1:0] regNumQ;
  accSizeE         sizeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      offsetQ <= '0;
      dataQ   <= '0;
      regNumQ <= '0;
      sizeQ   <= SZ_BYTE;
    end else if (strobes.capture) begin
      baseQ   <= reqBase;
      offsetQ <= offsetNext;
      dataQ   <= reqData;
      regNumQ <= reqBaseNum;
      sizeQ   <= reqSize;
    end
  end

  logic [OFFW-1:0]  sizeMask;
  logic [LANES-1:0] placedStrb;

  always_comb begin
    sizeMask     = OFFW'((32'd1 << sizeQ) - 32'd1);
    opMisaligned = |(baseQ[OFFW-1:0] & sizeMask);
    opBaseZero   = (regNumQ == '0);
  end

  pisu_lane_place #(.LANES(LANES)) uPlace (
    .sizeSel (sizeQ),
    .laneOff (baseQ[OFFW-1:0]),
    .value   (dataQ),
    .strb    (placedStrb),
    .data    (memData)
  );

  assign memStrb  = strobes.issue ? placedStrb : '0;
  assign memAddr  = baseQ;
  assign wbData   = baseQ + offsetQ;
  assign wbRegNum = regNumQ;
endmodule

// File: rtl/pisu_control.sv
module pisu_control
  import pisu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReady,
  input  logic        opBad,
  output ctrlStrobesT strobes,
  output logic        reqReady,
  output logic        memValid,
  output logic        wbValid,
  output logic        faultActive
);
  ctrlStateE state;
  ctrlStateE stateNext;
  logic      issuing;

  always_comb begin
    reqReady        = (state == ST_IDLE);
    issuing         = (state == ST_ISSUE);
    memValid        = issuing && !opBad;
    faultActive     = issuing && opBad;
    wbValid         = memValid && memReady;
    strobes.capture = reqReady && reqValid;
    strobes.issue   = memValid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (strobes.capture) stateNext = ST_ISSUE;
      ST_ISSUE: if (opBad || memReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/postinc_store_unit.sv
module postinc_store_unit
  import pisu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int IMMW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqSize,
  input  logic              reqIndexed,
  input  logic [REGW-1:0]   reqBaseNum,
  input  logic [XLEN-1:0]   reqBase,
  input  logic [XLEN-1:0]   reqIndex,
  input  logic [IMMW-1:0]   reqImm,
  input  logic [XLEN-1:0]   reqData,
  output logic              memValid,
  input  logic              memReady,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN/8-1:0] memStrb,
  output logic [XLEN-1:0]   memData,
  output logic              wbValid,
  output logic [REGW-1:0]   wbRegNum,
  output logic [XLEN-1:0]   wbData,
  output logic              alignFault,
  output logic              formFault
);
  ctrlStrobesT strobes;
  logic        opMisaligned;
  logic        opBaseZero;
  logic        faultActive;

  pisu_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReady    (memReady),
    .opBad       (opMisaligned || opBaseZero),
    .strobes     (strobes),
    .reqReady    (reqReady),
    .memValid    (memValid),
    .wbValid     (wbValid),
    .faultActive (faultActive)
  );

  pisu_datapath #(.XLEN(XLEN), .REGW(REGW), .IMMW(IMMW)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqSize      (accSizeE'(reqSize)),
    .reqIndexed   (reqIndexed),
    .reqBaseNum   (reqBaseNum),
    .reqBase      (reqBase),
    .reqIndex     (reqIndex),
    .reqImm       (reqImm),
    .reqData      (reqData),
    .opMisaligned (opMisaligned),
    .opBaseZero   (opBaseZero),
    .memAddr      (memAddr),
    .memStrb      (memStrb),
    .memData      (memData),
    .wbRegNum     (wbRegNum),
    .wbData       (wbData)
  );

  assign alignFault = faultActive && opMisaligned;
  assign formFault  = faultActive && opBaseZero;
endmodule

// File: rtl/pisu_checker.sv
module pisu_checker #(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memValid,
  input logic              memReady,
  input logic [XLEN-1:0]   memAddr,
  input logic [XLEN/8-1:0] memStrb,
  input logic [XLEN-1:0]   memData,
  input logic              wbValid,
  input logic [REGW-1:0]   wbRegNum,
  input logic [XLEN-1:0]   wbData,
  input logic              alignFault,
  input logic              formFault
);
  AST_WB_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (memValid && memReady)); // R9

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memStrb)
                                 && $stable(memData) && $stable(wbData))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady); // R9

  AST_STRB_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ($countones(memStrb) == 1 || $countones(memStrb) == 2 ||
                  $countones(memStrb) == 4 || $countones(memStrb) == 8)); // R6

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ((memAddr[2:0] & 3'($countones(memStrb) - 1)) == 3'd0)); // R7

  AST_ALIGN_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!memValid && !wbValid)); // R7

  AST_ALIGN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> (!alignFault && reqReady)); // R7

  AST_FORM_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    formFault |-> (!memValid && !wbValid)); // R8

  AST_WB_REG_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbRegNum != '0)); // R8
endmodule

bind postinc_store_unit pisu_checker #(.XLEN(XLEN), .REGW(REGW)) uChecker (.*);

// File: tb/tb_postinc_store_unit.sv
`timescale 1ns/1ps
module tb_postinc_store_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSize = 2'd0;
  logic        reqIndexed = 1'b0;
  logic [4:0]  reqBaseNum = 5'd0;
  logic [63:0] reqBase = '0;
  logic [63:0] reqIndex = '0;
  logic [15:0] reqImm = '0;
  logic [63:0] reqData = '0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [63:0] memAddr;
  logic [7:0]  memStrb;
  logic [63:0] memData;
  logic        wbValid;
  logic [4:0]  wbRegNum;
  logic [63:0] wbData;
  logic        alignFault;
  logic        formFault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  postinc_store_unit dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expOffset(input logic [1:0] sz, input logic idx,
                                            input logic [15:0] imm, input logic [63:0] index);
    logic [15:0] f;
    if (idx) return index;
    if (sz == 2'd3) begin
      f = {imm[13:0], 2'b00};
      return {{48{f[15]}}, f};
    end
    return {{48{imm[15]}}, imm};
  endfunction

  function automatic logic [7:0] expStrb(input logic [1:0] sz, input logic [2:0] off);
    int n;
    n = 1 << sz;
    return 8'((((1 << n) - 1) << (8 - n - off)));
  endfunction

  function automatic logic [63:0] expLanes(input logic [1:0] sz, input logic [2:0] off, input logic [63:0] d);
    int n;
    logic [63:0] m;
    n = 1 << sz;
    m = (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 64'd1);
    return (d & m) << (8 * (8 - n - off));
  endfunction

  task automatic runOp(input logic [1:0] sz, input logic idx, input logic [4:0] bnum,
                       input logic [63:0] base, input logic [63:0] index,
                       input logic [15:0] imm, input logic [63:0] d, input int waitCycles);
    bit mis;
    bit zero;
    string offTag;
    logic [63:0] expWb;
    mis  = (base % (64'd1 << sz)) != 0;
    zero = (bnum == 5'd0);
    offTag = idx ? "R5" : (sz == 2'd3 ? "R4" : "R3");
    expWb = base + expOffset(sz, idx, imm, index);
    @(negedge clk);
    reqSize = sz; reqIndexed = idx; reqBaseNum = bnum; reqBase = base;
    reqIndex = index; reqImm = imm; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    if (mis || zero) begin
      chk(alignFault == mis, "R7 alignFault", 64'(alignFault), 64'(mis));
      chk(formFault == zero, "R8 formFault", 64'(formFault), 64'(zero));
      chk(!memValid && !wbValid, mis ? "R7 suppress" : "R8 suppress",
          64'({memValid, wbValid}), 64'd0);
      @(negedge clk); #1;
      chk(reqReady && !memValid && !wbValid && !alignFault && !formFault,
          mis ? "R7 return idle" : "R8 return idle",
          64'({reqReady, memValid, wbValid, alignFault, formFault}), 64'b10000);
    end else begin
      for (int w = 0; w < waitCycles; w++) begin
        chk(memValid && !wbValid && !reqReady, "R9 pending",
            64'({memValid, wbValid, reqReady}), 64'b100);
        reqValid = 1'b1;
        reqBase  = {$urandom, $urandom};
        reqBaseNum = 5'd7;
        @(negedge clk);
        reqValid = 1'b0;
        #1;
        chk(memAddr == base, "R9 hold address", memAddr, base);
      end
      memReady = 1'b1;
      #1;
      chk(memValid && wbValid, "R9 accept with writeback", 64'({memValid, wbValid}), 64'b11);
      chk(memAddr == base, "R1 old base address", memAddr, base);
      chk(memStrb == expStrb(sz, base[2:0]), "R6 strobes", 64'(memStrb), 64'(expStrb(sz, base[2:0])));
      chk(memData == expLanes(sz, base[2:0], d), "R6 lane data", memData, expLanes(sz, base[2:0], d));
      chk(wbData == expWb, {offTag, " R2 writeback value"}, wbData, expWb);
      chk(wbRegNum == bnum, "R2 writeback register", 64'(wbRegNum), 64'(bnum));
      @(negedge clk);
      memReady = 1'b0;
      #1;
      chk(reqReady && !memValid && !wbValid, "R9 back to idle",
          64'({reqReady, memValid, wbValid}), 64'b100);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(reqReady && !memValid && !wbValid && !alignFault && !formFault, "R10 in reset",
        64'({reqReady, memValid, wbValid, alignFault, formFault}), 64'b10000);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(reqReady && !memValid && !wbValid && !alignFault && !formFault, "R10 after reset",
        64'({reqReady, memValid, wbValid, alignFault, formFault}), 64'b10000);

    // directed corner cases
    runOp(2'd0, 1'b0, 5'd3,  64'h0000_0000_1000_0007, 64'd0, 16'hFFF0, 64'h1122_3344_5566_77A5, 0); // R3 R6 byte at lane 0
    runOp(2'd0, 1'b0, 5'd4,  64'h0000_0000_1000_0000, 64'd0, 16'h0001, 64'h0000_0000_0000_00C3, 2); // R6 byte at lane 7
    runOp(2'd1, 1'b1, 5'd5,  64'h0000_0000_2000_0002, 64'h100, 16'h0000, 64'hDEAD_BEEF_CAFE_1234, 1); // R5 R6
    runOp(2'd2, 1'b0, 5'd6,  64'h0000_0000_3000_0004, 64'd0, 16'h8000, 64'hAAAA_BBBB_0102_0304, 0); // R3 most negative
    runOp(2'd3, 1'b0, 5'd8,  64'h0000_0000_0000_2000, 64'd0, 16'hFFFF, 64'h0123_4567_89AB_CDEF, 0); // R4 -4
    runOp(2'd3, 1'b0, 5'd9,  64'h0000_0000_0000_2000, 64'd0, 16'h0005, 64'h1, 3);                   // R4 +20
    runOp(2'd3, 1'b0, 5'd10, 64'h0000_0000_0000_2000, 64'd0, 16'h4000, 64'h2, 0);                   // R4 top bits ignored
    runOp(2'd3, 1'b0, 5'd11, 64'h0000_0000_0000_2008, 64'd0, 16'h8001, 64'h3, 0);                   // R4 top bits ignored
    runOp(2'd3, 1'b1, 5'd31, 64'h0000_0000_0000_4000, 64'hFFFF_FFFF_FFFF_FF00, 16'h0, 64'h4, 1);    // R5 negative index
    runOp(2'd3, 1'b1, 5'd1,  64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 16'h0, 64'h5, 0);                     // R2 wraps
    runOp(2'd1, 1'b0, 5'd2,  64'h0000_0000_0000_1001, 64'd0, 16'h0010, 64'h6, 0);                   // R7 odd half
    runOp(2'd2, 1'b0, 5'd2,  64'h0000_0000_0000_1002, 64'd0, 16'h0010, 64'h7, 0);                   // R7 word at 2
    runOp(2'd3, 1'b1, 5'd2,  64'h0000_0000_0000_1004, 64'd8, 16'h0000, 64'h8, 0);                   // R7 dword at 4
    runOp(2'd2, 1'b0, 5'd0,  64'h0000_0000_0000_1000, 64'd0, 16'h0010, 64'h9, 0);                   // R8 base zero
    runOp(2'd1, 1'b1, 5'd0,  64'h0000_0000_0000_1003, 64'd0, 16'h0000, 64'hA, 0);                   // R7 R8 both

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  sz;
      logic [63:0] base;
      logic [4:0]  bnum;
      sz   = 2'($urandom_range(0, 3));
      base = {$urandom, $urandom};
      if ($urandom_range(0, 9) != 0) base = base & ~((64'd1 << sz) - 64'd1);
      bnum = 5'($urandom_range(1, 31));
      if ($urandom_range(0, 19) == 0) bnum = 5'd0;
      runOp(sz, 1'($urandom_range(0, 1)), bnum, base, {$urandom, $urandom},
            16'($urandom), {$urandom, $urandom}, $urandom_range(0, 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule